// File: doc/BRIEF.md
# Video Timing and Split-Line Generator

This block derives all raster timing for a tile-and-sprite video subsystem from a single 16 MHz master clock. A divide-by-three stage produces a pixel-clock enable of about 5.33 MHz. A divide-by-eight stage produces a 2 MHz processor clock enable. Two cascaded wrap counters track the pixel position within a 336-cycle scanline and the line position within a 280-line frame, which gives a refresh rate near 56 Hz. The vertical blank runs 18 lines longer than usual, which leaves software more time to load sprite data by hand.

The counters are decoded into three signals: visible area, horizontal blank and vertical blank. A flag logic stage produces three outputs at the top of vertical blank: a one-cycle strobe that swaps the two sprite frame buffers, a status bit that is cleared when it is read, and an interrupt that can be gated. This design has no pixel-overlap collision detector. Instead, a "sprite zero hit" flag rises as soon as a fixed number of 8-line tile rows has been drawn (four by default). Software polls this flag to split the screen between a fixed score bar and a scrolled playfield.

All counts are parameters. The defaults give the 336 x 280 frame, a 256 x 240 visible area and the split after line 32.

Top module: `video_timing_gen`

## Requirements
- R1: `pix_ce` is high for exactly one master cycle in every CLK_DIV (3). Its first pulse is in the third cycle after reset is released.
- R2: `cpu_ce` is high for exactly one master cycle in every CPU_DIV (8). Its first pulse is in the eighth cycle after reset is released.
- R3: `hcount` advances by one on each `pix_ce` and wraps from H_TOTAL-1 (335) to 0. `hblank` is high when `hcount` >= H_VIS (256).
- R4: `vcount` advances by one when `hcount` wraps and runs from 0 to V_TOTAL-1 (279) before it returns to 0.
- R5: `vblank` is high exactly when `vcount` >= V_VIS (240). `active` is high exactly when `hcount` < H_VIS and `vcount` < V_VIS.
- R6: `hit_flag` goes high on the same clock edge that `vcount` becomes TILE_H*HIT_ROWS (32). It stays high through vertical blank and clears on the edge that `vcount` returns to 0.
- R7: `swap_pulse` is high for exactly one master cycle per frame. That cycle is the first cycle in which `vcount` = V_VIS and `hcount` = 0.
- R8: `vbl_status` sets on the edge that `vcount` becomes V_VIS. It clears on a clock edge where `stat_rd` is high, or on the edge that `vcount` returns to 0. If `stat_rd` is high on the edge where the status is set, the set wins.
- R9: `irq` equals `vbl_status` while `irq_en` is high, and is low while `irq_en` is low.
- R10: While `rst` is high at a clock edge, every counter and flag returns to zero. All outputs are then low, except the `active` decode for position (0,0), which is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 16 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_rd | input | 1 | Read strobe that clears the vertical-blank status |
| irq_en | input | 1 | Interrupt enable |
| pix_ce | output | 1 | Pixel clock enable, one cycle in three |
| cpu_ce | output | 1 | Processor clock enable, one cycle in eight |
| hcount | output | 9 | Pixel position in the line |
| vcount | output | 9 | Line position in the frame |
| active | output | 1 | Visible picture area |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |
| hit_flag | output | 1 | Line-count based split flag |
| vbl_status | output | 1 | Read-clear vertical blank status |
| irq | output | 1 | Vertical blank interrupt |
| swap_pulse | output | 1 | Sprite buffer swap strobe |

## Verification
The embedded properties assume that `stat_rd` and `irq_en` change only between clock edges. They also assume the parameters describe a sane raster: the visible area and the split line lie inside the frame, and the split line is not zero. The bench runs a reduced raster (20 x 14 cycles, split at line 4) so that several whole frames fit in a short run. It drives its inputs on falling edges only. It places reads both inside vertical blank and on the exact edge where the status is set, and it toggles the interrupt enable between frames.

// File: rtl/vt_pkg.sv
package vt_pkg;

    // Counter width for a count range of n values (never below one bit).
    function automatic int ctr_bits(input int n);
        return (n > 2) ? $clog2(n) : 1;
    endfunction

    // Next-state action for the vertical blank status bit.
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_SET   = 2'd1,
        ST_CLEAR = 2'd2
    } stat_op_e;

endpackage

// File: rtl/vt_clk_div.sv
module vt_clk_div
    import vt_pkg::*;
#(
    parameter int DIV = 3
) (
    input  logic clk,
    input  logic rst,
    output logic ce
);
    localparam int W = ctr_bits(DIV);

    generate
        if (DIV <= 1) begin : g_pass
            assign ce = 1'b1;
        end else begin : g_div
            logic [W-1:0] cnt;

            assign ce = (cnt == W'(DIV - 1));

            always_ff @(posedge clk) begin
                if (rst)     cnt <= '0;
                else if (ce) cnt <= '0;
                else         cnt <= cnt + 1'b1;
            end

            // R1 / R2: an enable never lasts two cycles in a row
            a_r1_r2_single_cycle: assert property (@(posedge clk) disable iff (rst)
                ce |=> !ce);
        end
    endgenerate
endmodule

// File: rtl/vt_wrap_counter.sv
module vt_wrap_counter
    import vt_pkg::*;
#(
    parameter int SPAN = 336,
    localparam int W = ctr_bits(SPAN)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         last
);
    assign last = (count == W'(SPAN - 1));

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (inc)  count <= last ? '0 : count + 1'b1;
    end

    a_r3_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (inc && last) |=> (count == '0));

    a_r3_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(count));

    a_r3_r4_in_range: assert property (@(posedge clk) disable iff (rst)
        count <= W'(SPAN - 1));
endmodule

// File: rtl/vt_flags.sv
module vt_flags
    import vt_pkg::*;
#(
    parameter int H_VIS    = 256,
    parameter int V_VIS    = 240,
    parameter int HIT_LINE = 32,
    parameter int HW       = 9,
    parameter int VW       = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pix_ce,
    input  logic          h_last,
    input  logic          v_last,
    input  logic [HW-1:0] hcount,
    input  logic [VW-1:0] vcount,
    input  logic          stat_rd,
    input  logic          irq_en,
    output logic          active,
    output logic          hblank,
    output logic          vblank,
    output logic          hit_flag,
    output logic          vbl_status,
    output logic          irq,
    output logic          swap_pulse
);
    logic     line_end, enter_vbl, enter_hit, enter_top;
    stat_op_e stat_op;
    logic     hit_q, stat_q, swap_q;

    // Position decodes
    assign hblank = (hcount >= HW'(H_VIS));
    assign vblank = (vcount >= VW'(V_VIS));
    assign active = !hblank && !vblank;

    // Line-boundary events, all qualified by the pixel enable
    always_comb begin
        line_end  = pix_ce && h_last;
        enter_vbl = line_end && (vcount == VW'(V_VIS - 1));
        enter_hit = line_end && (vcount == VW'(HIT_LINE - 1));
        enter_top = line_end && v_last;
        if (enter_vbl)                  stat_op = ST_SET;
        else if (enter_top || stat_rd)  stat_op = ST_CLEAR;
        else                            stat_op = ST_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q  <= 1'b0;
            stat_q <= 1'b0;
            swap_q <= 1'b0;
        end else begin
            swap_q <= enter_vbl;
            if (enter_hit)      hit_q <= 1'b1;
            else if (enter_top) hit_q <= 1'b0;
            unique case (stat_op)
                ST_SET:   stat_q <= 1'b1;
                ST_CLEAR: stat_q <= 1'b0;
                default:  stat_q <= stat_q;
            endcase
        end
    end

    assign hit_flag   = hit_q;
    assign vbl_status = stat_q;
    assign swap_pulse = swap_q;
    assign irq        = stat_q && irq_en;

    // R7: the swap strobe is a single master cycle
    a_r7_swap_single: assert property (@(posedge clk) disable iff (rst)
        swap_q |=> !swap_q);

    // R6: the split flag is never high on the top line
    a_r6_hit_low_on_top: assert property (@(posedge clk) disable iff (rst)
        (vcount == '0) |-> !hit_q);

    // R8: the status bit only lives inside vertical blank
    a_r8_status_in_vblank: assert property (@(posedge clk) disable iff (rst)
        stat_q |-> vblank);

    // R8: a read that does not meet a set clears the status
    a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !enter_vbl) |=> !stat_q);

    // R7: the swap strobe sits at the first pixel of vertical blank
    a_r7_swap_position: assert property (@(posedge clk) disable iff (rst)
        swap_q |-> (vcount == VW'(V_VIS) && hcount == '0));
endmodule

// File: rtl/video_timing_gen.sv
module video_timing_gen
    import vt_pkg::*;
#(
    parameter int CLK_DIV  = 3,
    parameter int CPU_DIV  = 8,
    parameter int H_TOTAL  = 336,
    parameter int H_VIS    = 256,
    parameter int V_TOTAL  = 280,
    parameter int V_VIS    = 240,
    parameter int TILE_H   = 8,
    parameter int HIT_ROWS = 4,
    localparam int HW = ctr_bits(H_TOTAL),
    localparam int VW = ctr_bits(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stat_rd,
    input  logic          irq_en,
    output logic          pix_ce,
    output logic          cpu_ce,
    output logic [HW-1:0] hcount,
    output logic [VW-1:0] vcount,
    output logic          active,
    output logic          hblank,
    output logic          vblank,
    output logic          hit_flag,
    output logic          vbl_status,
    output logic          irq,
    output logic          swap_pulse
);
    localparam int HIT_LINE = TILE_H * HIT_ROWS;

    logic h_last, v_last, v_inc;

    vt_clk_div #(.DIV(CLK_DIV)) i_pix_div (.clk(clk), .rst(rst), .ce(pix_ce));
    vt_clk_div #(.DIV(CPU_DIV)) i_cpu_div (.clk(clk), .rst(rst), .ce(cpu_ce));

    assign v_inc = pix_ce && h_last;

    vt_wrap_counter #(.SPAN(H_TOTAL)) i_hcnt (
        .clk(clk), .rst(rst), .inc(pix_ce), .count(hcount), .last(h_last));

    vt_wrap_counter #(.SPAN(V_TOTAL)) i_vcnt (
        .clk(clk), .rst(rst), .inc(v_inc), .count(vcount), .last(v_last));

    vt_flags #(
        .H_VIS(H_VIS), .V_VIS(V_VIS), .HIT_LINE(HIT_LINE), .HW(HW), .VW(VW)
    ) i_flags (
        .clk(clk), .rst(rst), .pix_ce(pix_ce), .h_last(h_last), .v_last(v_last),
        .hcount(hcount), .vcount(vcount), .stat_rd(stat_rd), .irq_en(irq_en),
        .active(active), .hblank(hblank), .vblank(vblank), .hit_flag(hit_flag),
        .vbl_status(vbl_status), .irq(irq), .swap_pulse(swap_pulse));

    // R4: the line counter moves only on a line wrap
    a_r4_line_step: assert property (@(posedge clk) disable iff (rst)
        !v_inc |=> $stable(vcount));
endmodule

// File: tb/test_video_timing_gen.sv
module test_video_timing_gen;
    import vt_pkg::*;

    localparam int CD = 3, PD = 8, HT = 20, HV = 12, VT = 14, VV = 10;
    localparam int TH = 2, HR = 2, HL = TH * HR;
    localparam int HW = ctr_bits(HT), VW = ctr_bits(VT);

    logic clk = 1'b0, rst = 1'b1, stat_rd = 1'b0, irq_en = 1'b0;
    logic pix_ce, cpu_ce, active, hblank, vblank, hit_flag, vbl_status, irq, swap_pulse;
    logic [HW-1:0] hcount;
    logic [VW-1:0] vcount;

    int total = 0, bad = 0;
    int n = 0;          // edges since reset release
    int m_stat = 0;     // model of the status bit
    bit done = 0;

    always #5 clk = ~clk;

    video_timing_gen #(
        .CLK_DIV(CD), .CPU_DIV(PD), .H_TOTAL(HT), .H_VIS(HV),
        .V_TOTAL(VT), .V_VIS(VV), .TILE_H(TH), .HIT_ROWS(HR)
    ) i_video_timing_gen (
        .clk(clk), .rst(rst), .stat_rd(stat_rd), .irq_en(irq_en),
        .pix_ce(pix_ce), .cpu_ce(cpu_ce), .hcount(hcount), .vcount(vcount),
        .active(active), .hblank(hblank), .vblank(vblank), .hit_flag(hit_flag),
        .vbl_status(vbl_status), .irq(irq), .swap_pulse(swap_pulse));

    function automatic int m_h(int k); return (k / CD) % HT; endfunction
    function automatic int m_v(int k); return ((k / CD) / HT) % VT; endfunction

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d (n=%0d)", tag, act, exp, n);
        end
    endtask

    // Compare every output with the model at the current position.
    task automatic check_all();
        int h = m_h(n), v = m_v(n);
        chk("R1 pix_ce", pix_ce, (n % CD) == CD - 1);
        chk("R2 cpu_ce", cpu_ce, (n % PD) == PD - 1);
        chk("R3 hcount", hcount, h);
        chk("R3 hblank", hblank, h >= HV);
        chk("R4 vcount", vcount, v);
        chk("R5 vblank", vblank, v >= VV);
        chk("R5 active", active, (h < HV) && (v < VV));
        chk("R6 hit_flag", hit_flag, v >= HL);
        chk("R7 swap_pulse", swap_pulse, (v == VV) && (h == 0) && (n % CD == 0));
        chk("R8 vbl_status", vbl_status, m_stat);
        chk("R9 irq", irq, m_stat && irq_en);
    endtask

    // One master cycle: update the model for the coming edge, then sample.
    task automatic step();
        bit ce_pre = (n % CD) == CD - 1;
        bit lend = ce_pre && (m_h(n) == HT - 1);
        @(posedge clk);
        if (lend && m_v(n) == VV - 1)      m_stat = 1;
        else if (lend && m_v(n) == VT - 1) m_stat = 0;
        else if (stat_rd)                  m_stat = 0;
        n++;
        @(negedge clk);
        check_all();
    endtask

    function automatic bit before_vbl_edge(int k);
        return ((k % CD) == CD - 1) && m_h(k) == HT - 1 && m_v(k) == VV - 1;
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 pix_ce", pix_ce, 0);
        chk("R10 cpu_ce", cpu_ce, 0);
        chk("R10 hcount", hcount, 0);
        chk("R10 vcount", vcount, 0);
        chk("R10 flags", {hit_flag, vbl_status, irq, swap_pulse, vblank, hblank}, 0);
        chk("R10 active", active, 1);
        rst = 1'b0;
        n = 0;
        m_stat = 0;
        check_all();
    endtask

    // Full frame, no reads: enables, counters, decodes, split and swap.
    task automatic t_free_frame();
        int swaps = 0, hits = 0;
        for (int i = 0; i < CD * HT * VT + 5; i++) begin
            step();
            if (swap_pulse) swaps++;
            if (hit_flag && m_v(n) == HL && m_h(n) == 0 && n % CD == 0) hits++;
        end
        chk("R7 one swap per frame", swaps, 1);
        chk("R6 split reached once", hits, 1);
        chk("R4 back at top", m_v(n), 0);
    endtask

    // Reads inside vertical blank and on the set edge.
    task automatic t_status_read();
        while (!before_vbl_edge(n)) step();
        stat_rd = 1'b1;
        step();
        stat_rd = 1'b0;
        chk("R8 set wins over read", vbl_status, 1);
        repeat (7) step();
        chk("R8 status held", vbl_status, 1);
        stat_rd = 1'b1;
        step();
        stat_rd = 1'b0;
        chk("R8 read clears", vbl_status, 0);
        repeat (CD * HT * 2) step();
        chk("R8 stays clear", vbl_status, 0);
        while (m_v(n) != 0) step();
    endtask

    // Interrupt follows status only while enabled.
    task automatic t_irq_gate();
        irq_en = 1'b1;
        while (!before_vbl_edge(n)) step();
        step();
        chk("R9 irq raised", irq, 1);
        irq_en = 1'b0;
        step();
        chk("R9 irq masked", irq, 0);
        irq_en = 1'b1;
        step();
        chk("R9 irq re-enabled", irq, 1);
        while (m_v(n) != 0) step();
        chk("R9 irq drops at top", irq, 0);
        chk("R8 top clears status", vbl_status, 0);
        irq_en = 1'b0;
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_free_frame();
        t_status_read();
        t_irq_gate();
        t_free_frame();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule